// File: doc/BRIEF.md
# Synthesizer Divider Parameter Search Engine

This block chooses the settings of a frequency synthesizer built from an input divider, a feedback multiplier and an output divider. A start pulse captures a reference frequency and a wanted output frequency, both in kHz. The engine then walks through the candidate divider settings. It keeps the comparison frequency (reference over input divider) and the oscillator frequency (reference times multiplier over input divider) inside their legal bands. It returns the setting whose output frequency lies nearest the target.

Every quotient the search needs comes from one shared multi-cycle restoring divider, so the engine is small but takes many cycles. Software or a sequencer writes the two frequencies, pulses start and waits for the done strobe. It then reads the three divider values, the frequency they produce and an error flag.

Top module: `synth_div_search`

## Requirements
- R1: After reset, busy, done and error are 0, and the divider, multiplier, output-divider and frequency outputs are all 0.
- R2: A start pulse while idle raises busy on the next cycle. A start pulse while busy is ignored: the run in progress finishes with the result for the frequencies captured first.
- R3: Any result reported without error keeps the comparison frequency within 10 000..300 000 kHz and the oscillator frequency within 600 000..1 200 000 kHz.
- R4: Any result reported without error has an input divider in 1..80, a multiplier in 1..64 and an output divider in 1..128.
- R5: The input divider range runs from max(ceil(fin/300000),1) to min(floor(fin/10000),80). The multiplier range runs from max(ceil(600000/fin)·Dlo,1) to min(floor(1200000·Dhi/fin),64). For each multiplier, the input divider is narrowed to the values that keep the oscillator in band.
- R6: For each candidate, the oscillator frequency is floor(fin·M/D). The output divider is that value divided by fout, rounded to nearest with halves rounded up, then clamped to 1..128. The reported frequency is floor(oscillator/output divider).
- R7: Multipliers are scanned upward and, within each, input dividers upward. A candidate replaces the best only when its absolute error is strictly smaller, so of equal errors the earliest wins.
- R8: The search stops as soon as a candidate's frequency equals the target exactly.
- R9: A zero reference, a zero target, an empty divider or multiplier range, or no accepted candidate all end the run with error at 1 and the divider, multiplier, output-divider and frequency outputs at 0.
- R10: Done is a one-cycle pulse in which busy is already 0. The outputs keep their values from that pulse until the next run finishes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search with the present frequencies |
| fin_khz | input | FREQ_W | Reference frequency in kHz |
| fout_khz | input | FREQ_W | Target output frequency in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search strobe |
| error | output | 1 | No usable setting was found |
| d_val | output | D_W | Chosen input divider |
| m_val | output | M_W | Chosen feedback multiplier |
| o_val | output | O_W | Chosen output divider |
| f_khz | output | FREQ_W | Frequency produced by the chosen setting |

## Verification
Busy is due one cycle after start. Each divider use takes 34 cycles (issue, 32 steps, result), so the run length depends on how many candidates are visited. A hit on the first candidate finishes about 308 cycles after start, while a full scan takes tens of thousands of cycles. The bench therefore waits on the done strobe and samples every result at the falling edge of the cycle in which done is high. It checks early termination as a bound on that wait. It then checks one and several cycles later that done has dropped and that the outputs have held.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

    localparam int NUM_W = 32;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DMIN,
        ST_DMAX,
        ST_MMIN,
        ST_MMAX,
        ST_RANGE,
        ST_DLO,
        ST_DHI,
        ST_VCO,
        ST_ODIV,
        ST_FOUT,
        ST_FINISH
    } search_st_e;

    typedef struct packed {
        logic [NUM_W-1:0] num;
        logic [NUM_W-1:0] den;
    } div_req_t;

    function automatic logic [NUM_W-1:0] umax(input logic [NUM_W-1:0] a, input logic [NUM_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [NUM_W-1:0] umin(input logic [NUM_W-1:0] a, input logic [NUM_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic [NUM_W-1:0] absdiff(input logic [NUM_W-1:0] a, input logic [NUM_W-1:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    function automatic logic [NUM_W-1:0] uclamp(input logic [NUM_W-1:0] v, input logic [NUM_W-1:0] lo,
                                                input logic [NUM_W-1:0] hi);
        return umin(umax(v, lo), hi);
    endfunction

endpackage

// File: rtl/synth_div_udiv.sv
module synth_div_udiv #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic [W-1:0] quo,
    output logic         done
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  rem_q;
    logic [W-1:0]  den_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic [W:0]    shifted;
    logic [W:0]    diff;

    assign shifted = {rem_q, quo[W-1]};
    assign diff    = shifted - {1'b0, den_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            den_q <= '0;
            quo   <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                rem_q <= '0;
                quo   <= num;
                den_q <= den;
                cnt_q <= CW'(W - 1);
                run_q <= 1'b1;
            end else if (run_q) begin
                if (!diff[W]) begin
                    rem_q <= diff[W-1:0];
                    quo   <= {quo[W-2:0], 1'b1};
                end else begin
                    rem_q <= shifted[W-1:0];
                    quo   <= {quo[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == '0) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/synth_div_best.sv
module synth_div_best
    import synth_div_pkg::*;
#(
    parameter int D_W = 7,
    parameter int M_W = 7,
    parameter int O_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             offer,
    input  logic [D_W-1:0]   cand_d,
    input  logic [M_W-1:0]   cand_m,
    input  logic [O_W-1:0]   cand_o,
    input  logic [NUM_W-1:0] cand_f,
    input  logic [NUM_W-1:0] target,
    output logic [D_W-1:0]   best_d,
    output logic [M_W-1:0]   best_m,
    output logic [O_W-1:0]   best_o,
    output logic [NUM_W-1:0] best_f,
    output logic             exact
);
    logic [NUM_W-1:0] best_err;
    logic [NUM_W-1:0] cand_err;
    logic             better;

    assign cand_err = absdiff(cand_f, target);
    assign better   = offer && (cand_err < best_err);
    assign exact    = offer && (cand_f == target);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            best_err <= '1;
            best_d   <= '0;
            best_m   <= '0;
            best_o   <= '0;
            best_f   <= '0;
        end else if (better) begin
            best_err <= cand_err;
            best_d   <= cand_d;
            best_m   <= cand_m;
            best_o   <= cand_o;
            best_f   <= cand_f;
        end
    end
endmodule

// File: rtl/synth_div_search.sv
module synth_div_search
    import synth_div_pkg::*;
#(
    parameter int FREQ_W  = 24,
    parameter int PFD_MIN = 10000,
    parameter int PFD_MAX = 300000,
    parameter int VCO_MIN = 600000,
    parameter int VCO_MAX = 1200000,
    parameter int D_LIM   = 80,
    parameter int M_LIM   = 64,
    parameter int O_LIM   = 128,
    parameter int D_W     = $clog2(D_LIM + 1),
    parameter int M_W     = $clog2(M_LIM + 1),
    parameter int O_W     = $clog2(O_LIM + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [FREQ_W-1:0] fin_khz,
    input  logic [FREQ_W-1:0] fout_khz,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [D_W-1:0]    d_val,
    output logic [M_W-1:0]    m_val,
    output logic [O_W-1:0]    o_val,
    output logic [FREQ_W-1:0] f_khz
);
    localparam logic [NUM_W-1:0] K_PFD_MIN = NUM_W'(PFD_MIN);
    localparam logic [NUM_W-1:0] K_PFD_MAX = NUM_W'(PFD_MAX);
    localparam logic [NUM_W-1:0] K_VCO_MIN = NUM_W'(VCO_MIN);
    localparam logic [NUM_W-1:0] K_VCO_MAX = NUM_W'(VCO_MAX);
    localparam logic [NUM_W-1:0] K_ONE     = NUM_W'(1);

    search_st_e       st;
    logic [NUM_W-1:0] fin_q, fout_q, dmin_q, dmax_q, mmin_q, mmax_q;
    logic [NUM_W-1:0] m_q, d_q, dhi_q, vco_q, odiv_q;
    logic             wait_q;

    div_req_t         req;
    logic             div_state, div_go, div_done;
    logic [NUM_W-1:0] div_quo;
    logic             m_last, offer, exact, clear;
    logic [D_W-1:0]   best_d;
    logic [M_W-1:0]   best_m;
    logic [O_W-1:0]   best_o;
    logic [NUM_W-1:0] best_f;

    // operand selection for the shared divider
    always_comb begin
        req.num   = '0;
        req.den   = K_ONE;
        div_state = 1'b1;
        case (st)
            ST_DMIN: begin req.num = fin_q + K_PFD_MAX - K_ONE;     req.den = K_PFD_MAX; end
            ST_DMAX: begin req.num = fin_q;                          req.den = K_PFD_MIN; end
            ST_MMIN: begin req.num = K_VCO_MIN + fin_q - K_ONE;      req.den = fin_q;     end
            ST_MMAX: begin req.num = K_VCO_MAX * dmax_q;             req.den = fin_q;     end
            ST_DLO:  begin req.num = fin_q * m_q + K_VCO_MAX - K_ONE; req.den = K_VCO_MAX; end
            ST_DHI:  begin req.num = fin_q * m_q;                    req.den = K_VCO_MIN; end
            ST_VCO:  begin req.num = fin_q * m_q;                    req.den = d_q;       end
            ST_ODIV: begin req.num = vco_q + (fout_q >> 1);          req.den = fout_q;    end
            ST_FOUT: begin req.num = vco_q;                          req.den = odiv_q;    end
            default: div_state = 1'b0;
        endcase
    end

    assign div_go = div_state && !wait_q;
    assign m_last = (m_q >= mmax_q);
    assign offer  = (st == ST_FOUT) && div_done;
    assign clear  = (st == ST_IDLE) && start;

    synth_div_udiv #(.W(NUM_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .go   (div_go),
        .num  (req.num),
        .den  (req.den),
        .quo  (div_quo),
        .done (div_done)
    );

    synth_div_best #(.D_W(D_W), .M_W(M_W), .O_W(O_W)) u_best (
        .clk    (clk),
        .rst    (rst),
        .clear  (clear),
        .offer  (offer),
        .cand_d (d_q[D_W-1:0]),
        .cand_m (m_q[M_W-1:0]),
        .cand_o (odiv_q[O_W-1:0]),
        .cand_f (div_quo),
        .target (fout_q),
        .best_d (best_d),
        .best_m (best_m),
        .best_o (best_o),
        .best_f (best_f),
        .exact  (exact)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            wait_q <= 1'b0;
            busy   <= 1'b0;
            done   <= 1'b0;
            error  <= 1'b0;
            d_val  <= '0;
            m_val  <= '0;
            o_val  <= '0;
            f_khz  <= '0;
            fin_q  <= '0;
            fout_q <= '0;
            dmin_q <= '0;
            dmax_q <= '0;
            mmin_q <= '0;
            mmax_q <= '0;
            m_q    <= '0;
            d_q    <= '0;
            dhi_q  <= '0;
            vco_q  <= '0;
            odiv_q <= '0;
        end else begin
            done <= 1'b0;
            if (div_done)    wait_q <= 1'b0;
            else if (div_go) wait_q <= 1'b1;

            case (st)
                ST_IDLE: if (start) begin
                    busy   <= 1'b1;
                    fin_q  <= NUM_W'(fin_khz);
                    fout_q <= NUM_W'(fout_khz);
                    st     <= (fin_khz == '0 || fout_khz == '0) ? ST_FINISH : ST_DMIN;
                end
                ST_DMIN: if (div_done) begin
                    dmin_q <= umax(div_quo, K_ONE);
                    st     <= ST_DMAX;
                end
                ST_DMAX: if (div_done) begin
                    dmax_q <= umin(div_quo, NUM_W'(D_LIM));
                    st     <= ST_MMIN;
                end
                ST_MMIN: if (div_done) begin
                    mmin_q <= umax(div_quo * dmin_q, K_ONE);
                    st     <= ST_MMAX;
                end
                ST_MMAX: if (div_done) begin
                    mmax_q <= umin(div_quo, NUM_W'(M_LIM));
                    st     <= ST_RANGE;
                end
                ST_RANGE: begin
                    if (dmin_q > dmax_q || mmin_q > mmax_q) begin
                        st <= ST_FINISH;
                    end else begin
                        m_q <= mmin_q;
                        st  <= ST_DLO;
                    end
                end
                ST_DLO: if (div_done) begin
                    d_q <= umax(dmin_q, div_quo);
                    st  <= ST_DHI;
                end
                ST_DHI: if (div_done) begin
                    dhi_q <= umin(dmax_q, div_quo);
                    if (d_q > umin(dmax_q, div_quo)) begin
                        if (m_last) st <= ST_FINISH;
                        else begin
                            m_q <= m_q + K_ONE;
                            st  <= ST_DLO;
                        end
                    end else begin
                        st <= ST_VCO;
                    end
                end
                ST_VCO: if (div_done) begin
                    vco_q <= div_quo;
                    st    <= ST_ODIV;
                end
                ST_ODIV: if (div_done) begin
                    odiv_q <= uclamp(div_quo, K_ONE, NUM_W'(O_LIM));
                    st     <= ST_FOUT;
                end
                ST_FOUT: if (div_done) begin
                    if (exact) begin
                        st <= ST_FINISH;
                    end else if (d_q < dhi_q) begin
                        d_q <= d_q + K_ONE;
                        st  <= ST_VCO;
                    end else if (m_last) begin
                        st <= ST_FINISH;
                    end else begin
                        m_q <= m_q + K_ONE;
                        st  <= ST_DLO;
                    end
                end
                ST_FINISH: begin
                    busy  <= 1'b0;
                    done  <= 1'b1;
                    error <= (best_m == '0);
                    d_val <= best_d;
                    m_val <= best_m;
                    o_val <= best_o;
                    f_khz <= best_f[FREQ_W-1:0];
                    st    <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/synth_div_search_chk.sv
module synth_div_search_chk #(
    parameter int FREQ_W  = 24,
    parameter int PFD_MIN = 10000,
    parameter int PFD_MAX = 300000,
    parameter int VCO_MIN = 600000,
    parameter int VCO_MAX = 1200000,
    parameter int D_LIM   = 80,
    parameter int M_LIM   = 64,
    parameter int O_LIM   = 128,
    parameter int D_W     = 7,
    parameter int M_W     = 7,
    parameter int O_W     = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [FREQ_W-1:0] fin_khz,
    input logic              busy,
    input logic              done,
    input logic              error,
    input logic [D_W-1:0]    d_val,
    input logic [M_W-1:0]    m_val,
    input logic [O_W-1:0]    o_val,
    input logic [FREQ_W-1:0] f_khz
);
    logic [FREQ_W-1:0] fin_cap;
    longint            fin_l, d_l, m_l;

    always_ff @(posedge clk) begin
        if (rst) fin_cap <= '0;
        else if (start && !busy) fin_cap <= fin_khz;
    end

    assign fin_l = longint'(fin_cap);
    assign d_l   = longint'(d_val);
    assign m_l   = longint'(m_val);

    assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> busy);

    assert_pfd_band_R3: assert property (@(posedge clk) disable iff (rst)
        done && !error |-> (d_l * PFD_MIN <= fin_l) && (fin_l <= d_l * PFD_MAX));

    assert_vco_band_R3: assert property (@(posedge clk) disable iff (rst)
        done && !error |-> (d_l * VCO_MIN <= fin_l * m_l) && (fin_l * m_l <= d_l * VCO_MAX));

    assert_div_limits_R4: assert property (@(posedge clk) disable iff (rst)
        done && !error |-> (d_val != '0) && (int'(d_val) <= D_LIM) && (m_val != '0) &&
                           (int'(m_val) <= M_LIM) && (o_val != '0) && (int'(o_val) <= O_LIM));

    assert_error_zeroes_R9: assert property (@(posedge clk) disable iff (rst)
        done && error |-> (d_val == '0) && (m_val == '0) && (o_val == '0) && (f_khz == '0));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !busy && !$past(busy) |-> $stable(d_val) && $stable(m_val) && $stable(o_val) &&
                                  $stable(f_khz) && $stable(error));
endmodule

bind synth_div_search synth_div_search_chk #(
    .FREQ_W(FREQ_W), .PFD_MIN(PFD_MIN), .PFD_MAX(PFD_MAX), .VCO_MIN(VCO_MIN),
    .VCO_MAX(VCO_MAX), .D_LIM(D_LIM), .M_LIM(M_LIM), .O_LIM(O_LIM),
    .D_W(D_W), .M_W(M_W), .O_W(O_W)
) u_chk (
    .clk(clk), .rst(rst), .start(start), .fin_khz(fin_khz), .busy(busy), .done(done),
    .error(error), .d_val(d_val), .m_val(m_val), .o_val(o_val), .f_khz(f_khz)
);

// File: tb/synth_div_search_tb.sv
module synth_div_search_tb_top;
    localparam int FW = 24;
    localparam int NV = 10;

    typedef struct packed {
        int fin; int fout; int d; int m; int o; int f; int er;
    } vec_t;

    // fin, fout, D, M, DOUT, freq, error
    localparam vec_t VECS [NV] = '{
        '{100000, 100000, 1,  6,   6, 100000, 0},
        '{100000, 300000, 1,  6,   2, 300000, 0},
        '{100000, 250000, 1, 10,   4, 250000, 0},
        '{100000, 700000, 1,  7,   1, 700000, 0},
        '{400000, 200000, 2,  4,   4, 200000, 0},
        '{ 30000, 600000, 1, 20,   1, 600000, 0},
        '{100000,   1000, 1,  6, 128,   4687, 0},
        '{  5000, 100000, 0,  0,   0,      0, 1},
        '{     0, 100000, 0,  0,   0,      0, 1},
        '{100000,      0, 0,  0,   0,      0, 1}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [FW-1:0] fin_khz = '0;
    logic [FW-1:0] fout_khz = '0;
    logic          busy, done, error;
    logic [6:0]    d_val, m_val;
    logic [7:0]    o_val;
    logic [FW-1:0] f_khz;

    int errors = 0;
    int checks = 0;
    int total_cyc = 0;

    always #5 clk = ~clk;

    synth_div_search dut_i (
        .clk(clk), .rst(rst), .start(start), .fin_khz(fin_khz), .fout_khz(fout_khz),
        .busy(busy), .done(done), .error(error), .d_val(d_val), .m_val(m_val),
        .o_val(o_val), .f_khz(f_khz)
    );

    always @(posedge clk) begin
        total_cyc <= total_cyc + 1;
        if (total_cyc > 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog (R8) actual=%0d cycles expected=<190000", total_cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic launch(input int fin, input int fout);
        @(negedge clk);
        start    = 1'b1;
        fin_khz  = FW'(fin);
        fout_khz = FW'(fout);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done && cyc < 60000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) chk("R8 done timeout", 0, 1);
    endtask

    task automatic check_result(input string tag, input vec_t v);
        chk({tag, " R6 divider"},    int'(d_val), v.d);
        chk({tag, " R5 multiplier"}, int'(m_val), v.m);
        chk({tag, " R6 outdiv"},     int'(o_val), v.o);
        chk({tag, " R6 freq"},       int'(f_khz), v.f);
        chk({tag, " R9 error"},      int'(error), v.er);
    endtask

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 error", int'(error), 0);
        chk("R1 outputs", int'(d_val) + int'(m_val) + int'(o_val) + int'(f_khz), 0);
        rst = 1'b0;

        // vector table walk (R5, R6, R7, R9)
        for (int i = 0; i < NV; i++) begin
            launch(VECS[i].fin, VECS[i].fout);
            wait_done(cyc);
            check_result($sformatf("vec%0d", i), VECS[i]);
            if (i == 0) chk("R8 early stop within 400 cycles", int'(cyc < 400), 1);
            if (i == 6) chk("R7 tie keeps earliest multiplier", int'(m_val), 6);
        end

        // R2: busy next cycle, second start ignored
        @(negedge clk);
        start = 1'b1; fin_khz = FW'(100000); fout_khz = FW'(300000);
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", int'(busy), 1);
        @(negedge clk);
        start = 1'b1; fin_khz = FW'(30000); fout_khz = FW'(600000);
        @(negedge clk);
        start = 1'b0;
        wait_done(cyc);
        check_result("R2 ignored restart", VECS[1]);

        // R10: one-cycle done, outputs held
        @(negedge clk);
        chk("R10 done pulse", int'(done), 0);
        repeat (20) @(negedge clk);
        chk("R10 hold outdiv", int'(o_val), 2);
        chk("R10 hold multiplier", int'(m_val), 6);

        // R1: reset in the middle of a run
        launch(100000, 1000);
        repeat (50) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid-run busy", int'(busy), 0);
        chk("R1 mid-run outputs", int'(d_val) + int'(m_val) + int'(o_val) + int'(f_khz), 0);
        rst = 1'b0;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule